// File: doc/BRIEF.md
# Two-Sided Processor Mailbox

This block lets two processors that share one clock exchange 32-bit words and payload-free notifications. Each processor owns a side, A or B, with its own register port and its own interrupt line. On each side four transmit slots feed four receive slots on the opposite side. One full flag per slot and direction gives the handshake. The writer sees that flag inverted as transmit-empty. The reader sees it as receive-full. Reading the receive slot hands the slot back to the writer.

Each side also has four doorbell request bits in its control register. Setting one raises a sticky pending bit on the far side. The far side clears that bit by writing a one to it. No acknowledgement returns to the requester. The status and control fields list channels in reverse order: channel n sits at bit base+(3-n). Each side's interrupt is the OR of its transmit-empty, receive-full and doorbell-pending flags, each masked by its own enable bit.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset each side's status register reads 0x00F00000, with all transmit-empty flags at bits 20..23 set and everything else clear. Both control registers read 0 and both interrupts are low.
- R2: Per-side map: transmit slot n is at byte offset 4n, receive slot n at 0x10+4n, status at 0x20, control at 0x24. A write to transmit slot n on side A clears transmit-empty bit 20+(3-n) on A. On the next cycle it sets receive-full bit 24+(3-n) on B, and B's receive slot n returns the word.
- R3: A read of receive slot n on B clears B's receive-full n and sets A's transmit-empty n again.
- R4: A write to a transmit slot whose flag is already full replaces the held word and leaves both flags unchanged.
- R5: A write of 1 to control bit 16+(3-n) posts a doorbell. The request bit reads 1 for exactly one cycle. On the next edge the far side's pending bit 28+(3-n) is set and the request bit reads 0. The requester's own status shows no acknowledgement.
- R6: Writing 1 to a pending bit in the status register clears it. Writing 0 there, or writing to any other status bit, has no effect.
- R7: A side's interrupt is high exactly when some flag is set together with its enable bit in that side's control register. Transmit-empty n pairs with enable bit 20+(3-n), receive-full n with 24+(3-n), and pending n with 28+(3-n).
- R8: Control bits 20..31 read back as written and bits 0..15 read 0. Unmapped or misaligned offsets and transmit slots read 0, and status bit 9 reads 0. Writes to receive slots are ignored.
- R9: The B-to-A direction behaves like the A-to-B direction and is independent of it.
- R10: A write to transmit slot n and a read of receive slot n on the same cycle give the reader the old word. The slot then stays full and holds the new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe; a read of a receive slot pops it at the clock edge |
| a_addr | input | 6 | Side A byte offset |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, valid in the same cycle as a_rd |
| a_irq | output | 1 | Side A interrupt |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_addr | input | 6 | Side B byte offset |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data |
| b_irq | output | 1 | Side B interrupt |

## Verification
The bench builds the block with its defaults: four channels, 32-bit words and a 6-bit offset. At four channels every bit of the reversed status and control fields is populated, so a mistake in the mirrored bit order shows up in the exact status words the bench reads back. Those defaults also make the collision between a same-cycle write and pop reachable, along with the single-cycle lifetime of a doorbell request and each of the three interrupt sources on both sides.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;

    localparam int SLOTS    = 4;
    localparam int IDX_W    = 2;
    localparam int WORD_W   = 32;
    localparam int OFFS_W   = 6;

    localparam logic [31:0] OFF_TX_BASE = 32'h00;
    localparam logic [31:0] OFF_RX_BASE = 32'h10;
    localparam logic [31:0] OFF_STAT    = 32'h20;
    localparam logic [31:0] OFF_CTRL    = 32'h24;

    // Field bases; channel n lands at base + (SLOTS-1-n)
    localparam int GP_BASE  = 28;
    localparam int RF_BASE  = 24;
    localparam int TE_BASE  = 20;
    localparam int GR_BASE  = 16;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TX,
        SEL_RX,
        SEL_STAT,
        SEL_CTRL
    } sel_e;

    typedef struct packed {
        sel_e             sel;
        logic [IDX_W-1:0] idx;
    } acc_t;

    typedef struct packed {
        logic [SLOTS-1:0] gie;
        logic [SLOTS-1:0] rie;
        logic [SLOTS-1:0] tie;
    } en_t;

    function automatic int fbit(input int base, input int ch);
        return base + (SLOTS - 1 - ch);
    endfunction

    function automatic acc_t decode(input logic [31:0] a);
        acc_t r;
        r.sel = SEL_NONE;
        r.idx = a[3:2];
        if (a[1:0] == 2'b00) begin
            if (a < OFF_RX_BASE)
                r.sel = SEL_TX;
            else if (a < OFF_STAT)
                r.sel = SEL_RX;
            else if (a == OFF_STAT)
                r.sel = SEL_STAT;
            else if (a == OFF_CTRL)
                r.sel = SEL_CTRL;
        end
        return r;
    endfunction

endpackage

// File: rtl/ipc_mbx_lane.sv
module ipc_mbx_lane #(
    parameter int DW = ipc_mbx_pkg::WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic          full,
    output logic [DW-1:0] word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            word <= '0;
        end else if (push) begin
            // a push in the same cycle as a pop keeps the slot occupied
            full <= 1'b1;
            word <= wdata;
        end else if (pop) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/ipc_mbx_bell.sv
module ipc_mbx_bell (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic val,
    input  logic clr,
    output logic req,
    output logic pend
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req  <= 1'b0;
            pend <= 1'b0;
        end else begin
            if (load)
                req <= val;
            else if (req)
                req <= 1'b0;
            // a request landing on the clear cycle wins
            if (req)
                pend <= 1'b1;
            else if (clr)
                pend <= 1'b0;
        end
    end

endmodule

// File: rtl/ipc_mbx_port.sv
module ipc_mbx_port
    import ipc_mbx_pkg::*;
#(
    parameter int NCH = SLOTS,
    parameter int DW  = WORD_W,
    parameter int AW  = OFFS_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr,
    input  logic           rd,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    input  logic [NCH-1:0] tx_full,
    input  logic [NCH-1:0] rx_full,
    input  logic [DW-1:0]  rx_word [NCH],
    input  logic [NCH-1:0] req_q,
    input  logic [NCH-1:0] pend_q,
    output logic [NCH-1:0] tx_push,
    output logic [DW-1:0]  tx_word,
    output logic [NCH-1:0] rx_pop,
    output logic           req_load,
    output logic [NCH-1:0] req_val,
    output logic [NCH-1:0] pend_clr,
    output logic [DW-1:0]  rdata,
    output logic           irq
);

    acc_t            acc;
    en_t             en_q;
    logic [DW-1:0]   stat_w;
    logic [DW-1:0]   ctrl_w;

    assign acc     = decode(32'(addr));
    assign tx_word = wdata;
    assign req_load = wr && (acc.sel == SEL_CTRL);

    always_comb begin
        for (int n = 0; n < NCH; n++) begin
            tx_push[n]  = wr && (acc.sel == SEL_TX) && (acc.idx == IDX_W'(n));
            rx_pop[n]   = rd && (acc.sel == SEL_RX) && (acc.idx == IDX_W'(n));
            req_val[n]  = wdata[fbit(GR_BASE, n)];
            pend_clr[n] = wr && (acc.sel == SEL_STAT) && wdata[fbit(GP_BASE, n)];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (req_load) begin
            for (int n = 0; n < NCH; n++) begin
                en_q.gie[n] <= wdata[fbit(GP_BASE, n)];
                en_q.rie[n] <= wdata[fbit(RF_BASE, n)];
                en_q.tie[n] <= wdata[fbit(TE_BASE, n)];
            end
        end
    end

    always_comb begin
        stat_w = '0;
        ctrl_w = '0;
        for (int n = 0; n < NCH; n++) begin
            stat_w[fbit(GP_BASE, n)] = pend_q[n];
            stat_w[fbit(RF_BASE, n)] = rx_full[n];
            stat_w[fbit(TE_BASE, n)] = ~tx_full[n];
            ctrl_w[fbit(GP_BASE, n)] = en_q.gie[n];
            ctrl_w[fbit(RF_BASE, n)] = en_q.rie[n];
            ctrl_w[fbit(TE_BASE, n)] = en_q.tie[n];
            ctrl_w[fbit(GR_BASE, n)] = req_q[n];
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (acc.sel)
                SEL_RX: begin
                    for (int n = 0; n < NCH; n++)
                        if (acc.idx == IDX_W'(n))
                            rdata = rx_word[n];
                end
                SEL_STAT: rdata = stat_w;
                SEL_CTRL: rdata = ctrl_w;
                default:  rdata = '0;
            endcase
        end
    end

    always_comb begin
        irq = 1'b0;
        for (int n = 0; n < NCH; n++)
            irq = irq | (pend_q[n] & en_q.gie[n])
                      | (rx_full[n] & en_q.rie[n])
                      | (~tx_full[n] & en_q.tie[n]);
    end

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_mbx_pkg::*;
#(
    parameter int NCH = SLOTS,
    parameter int DW  = WORD_W,
    parameter int AW  = OFFS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a_wr,
    input  logic          a_rd,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    output logic          a_irq,
    input  logic          b_wr,
    input  logic          b_rd,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          b_irq
);

    localparam int SIDES = 2;

    // Direction d carries words written by side d to side 1-d
    logic [NCH-1:0] lane_full [SIDES];
    logic [DW-1:0]  lane_word [SIDES][NCH];
    logic [NCH-1:0] push      [SIDES];
    logic [NCH-1:0] pop       [SIDES];
    logic [NCH-1:0] req_val   [SIDES];
    logic [NCH-1:0] clr       [SIDES];
    logic [NCH-1:0] req_q     [SIDES];
    logic [NCH-1:0] pend_q    [SIDES];
    logic [DW-1:0]  txw       [SIDES];
    logic [SIDES-1:0] req_load;

    logic           wr_v    [SIDES];
    logic           rd_v    [SIDES];
    logic [AW-1:0]  addr_v  [SIDES];
    logic [DW-1:0]  wdata_v [SIDES];
    logic [DW-1:0]  rdata_v [SIDES];
    logic [SIDES-1:0] irq_v;

    assign wr_v[0]    = a_wr;
    assign wr_v[1]    = b_wr;
    assign rd_v[0]    = a_rd;
    assign rd_v[1]    = b_rd;
    assign addr_v[0]  = a_addr;
    assign addr_v[1]  = b_addr;
    assign wdata_v[0] = a_wdata;
    assign wdata_v[1] = b_wdata;
    assign a_rdata    = rdata_v[0];
    assign b_rdata    = rdata_v[1];
    assign a_irq      = irq_v[0];
    assign b_irq      = irq_v[1];

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        ipc_mbx_port #(.NCH(NCH), .DW(DW), .AW(AW)) u_port (
            .clk      (clk),
            .rst      (rst),
            .wr       (wr_v[s]),
            .rd       (rd_v[s]),
            .addr     (addr_v[s]),
            .wdata    (wdata_v[s]),
            .tx_full  (lane_full[s]),
            .rx_full  (lane_full[1-s]),
            .rx_word  (lane_word[1-s]),
            .req_q    (req_q[s]),
            .pend_q   (pend_q[1-s]),
            .tx_push  (push[s]),
            .tx_word  (txw[s]),
            .rx_pop   (pop[1-s]),
            .req_load (req_load[s]),
            .req_val  (req_val[s]),
            .pend_clr (clr[1-s]),
            .rdata    (rdata_v[s]),
            .irq      (irq_v[s])
        );
    end

    for (genvar d = 0; d < SIDES; d++) begin : g_dir
        for (genvar n = 0; n < NCH; n++) begin : g_ch
            ipc_mbx_lane #(.DW(DW)) u_lane (
                .clk   (clk),
                .rst   (rst),
                .push  (push[d][n]),
                .pop   (pop[d][n]),
                .wdata (txw[d]),
                .full  (lane_full[d][n]),
                .word  (lane_word[d][n])
            );
            ipc_mbx_bell u_bell (
                .clk  (clk),
                .rst  (rst),
                .load (req_load[d]),
                .val  (req_val[d][n]),
                .clr  (clr[d][n]),
                .req  (req_q[d][n]),
                .pend (pend_q[d][n])
            );
        end
    end

endmodule

// File: rtl/ipc_mbx_chk.sv
module ipc_mbx_chk
    import ipc_mbx_pkg::*;
#(
    parameter int NCH = SLOTS,
    parameter int AW  = OFFS_W
) (
    input logic             clk,
    input logic             rst,
    input logic             a_wr,
    input logic [AW-1:0]    a_addr,
    input logic             b_wr,
    input logic             b_rd,
    input logic [AW-1:0]    b_addr,
    input logic [SLOTS-1:0] b_gp_wbits,
    input logic             a_irq,
    input logic             b_irq,
    input logic [NCH-1:0]   full_ab,
    input logic [NCH-1:0]   full_ba,
    input logic [NCH-1:0]   gir_a,
    input logic [NCH-1:0]   gip_b
);

    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!a_irq && !b_irq));

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        localparam logic [AW-1:0] TX_OFF = AW'(4 * n);
        localparam logic [AW-1:0] RX_OFF = AW'(16 + 4 * n);

        p_push_fills_r2: assert property (@(posedge clk) disable iff (rst)
            (a_wr && a_addr == TX_OFF) |=> full_ab[n]);

        p_push_fills_r9: assert property (@(posedge clk) disable iff (rst)
            (b_wr && b_addr == TX_OFF) |=> full_ba[n]);

        p_pop_empties_r3: assert property (@(posedge clk) disable iff (rst)
            (b_rd && b_addr == RX_OFF && !(a_wr && a_addr == TX_OFF)) |=> !full_ab[n]);

        p_full_holds_r4: assert property (@(posedge clk) disable iff (rst)
            (full_ab[n] && !(b_rd && b_addr == RX_OFF)) |=> full_ab[n]);

        p_collide_keeps_r10: assert property (@(posedge clk) disable iff (rst)
            (a_wr && a_addr == TX_OFF && b_rd && b_addr == RX_OFF) |=> full_ab[n]);

        p_bell_moves_r5: assert property (@(posedge clk) disable iff (rst)
            (gir_a[n] && !(a_wr && a_addr == AW'(36))) |=> (gip_b[n] && !gir_a[n]));

        p_pend_sticky_r6: assert property (@(posedge clk) disable iff (rst)
            (gip_b[n] && !(b_wr && b_addr == AW'(32) && b_gp_wbits[SLOTS-1-n])) |=> gip_b[n]);
    end

endmodule

bind ipc_mailbox ipc_mbx_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .a_wr       (a_wr),
    .a_addr     (a_addr),
    .b_wr       (b_wr),
    .b_rd       (b_rd),
    .b_addr     (b_addr),
    .b_gp_wbits (b_wdata[ipc_mbx_pkg::GP_BASE +: ipc_mbx_pkg::SLOTS]),
    .a_irq      (a_irq),
    .b_irq      (b_irq),
    .full_ab    (lane_full[0]),
    .full_ba    (lane_full[1]),
    .gir_a      (req_q[0]),
    .gip_b      (pend_q[0])
);

// File: tb/sim_ipc_mailbox.sv
`timescale 1ns/1ps
module sim_ipc_mailbox;

    localparam logic [5:0] STAT = 6'h20;
    localparam logic [5:0] CTRL = 6'h24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        a_wr = 1'b0, a_rd = 1'b0, b_wr = 1'b0, b_rd = 1'b0;
    logic [5:0]  a_addr = '0, b_addr = '0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ipc_mailbox u0 (
        .clk(clk), .rst(rst),
        .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq(b_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input bit side, input logic [5:0] ad, input logic [31:0] d);
        if (side) begin b_wr = 1'b1; b_addr = ad; b_wdata = d; end
        else      begin a_wr = 1'b1; a_addr = ad; a_wdata = d; end
        @(negedge clk);
        a_wr = 1'b0;
        b_wr = 1'b0;
    endtask

    task automatic rd_chk(input bit side, input logic [5:0] ad,
                          input logic [31:0] exp, input string tag);
        if (side) begin b_rd = 1'b1; b_addr = ad; end
        else      begin a_rd = 1'b1; a_addr = ad; end
        #1;
        chk(tag, side ? b_rdata : a_rdata, exp);
        @(negedge clk);
        a_rd = 1'b0;
        b_rd = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 a_irq", 32'(a_irq), 0);
        chk("R1 b_irq", 32'(b_irq), 0);
        rd_chk(0, STAT, 32'h00F0_0000, "R1 A status");
        rd_chk(1, STAT, 32'h00F0_0000, "R1 B status");
        rd_chk(0, CTRL, 32'h0, "R1 A control");
        rd_chk(1, CTRL, 32'h0, "R1 B control");
    endtask

    task automatic t_data_ab;
        bus_wr(0, 6'h04, 32'hCAFE_0001);
        rd_chk(0, STAT, 32'h00B0_0000, "R2 A te1 cleared");
        rd_chk(1, STAT, 32'h04F0_0000, "R2 B rf1 set");
        rd_chk(1, 6'h14, 32'hCAFE_0001, "R2 B rx1 word");
        rd_chk(1, STAT, 32'h00F0_0000, "R3 B rf1 cleared");
        rd_chk(0, STAT, 32'h00F0_0000, "R3 A te1 restored");
    endtask

    task automatic t_overwrite;
        bus_wr(0, 6'h0C, 32'h0000_0011);
        bus_wr(0, 6'h0C, 32'h0000_0022);
        rd_chk(0, STAT, 32'h00E0_0000, "R4 A flags unchanged");
        rd_chk(1, STAT, 32'h01F0_0000, "R4 B flags unchanged");
        rd_chk(1, 6'h1C, 32'h0000_0022, "R4 newest word");
    endtask

    task automatic t_data_ba;
        bus_wr(1, 6'h00, 32'h0000_5A5A);
        rd_chk(1, STAT, 32'h0070_0000, "R9 B te0 cleared");
        rd_chk(0, STAT, 32'h08F0_0000, "R9 A rf0 set");
        rd_chk(0, 6'h10, 32'h0000_5A5A, "R9 A rx0 word");
        rd_chk(0, STAT, 32'h00F0_0000, "R9 A rf0 cleared");
        rd_chk(1, STAT, 32'h00F0_0000, "R9 B te0 restored");
    endtask

    task automatic t_doorbell;
        bus_wr(0, CTRL, 32'h0002_0000);
        rd_chk(0, CTRL, 32'h0002_0000, "R5 request visible one cycle");
        rd_chk(1, STAT, 32'h20F0_0000, "R5 B pending2 set");
        rd_chk(0, CTRL, 32'h0, "R5 request self-cleared");
        rd_chk(0, STAT, 32'h00F0_0000, "R5 no acknowledge on A");
    endtask

    task automatic t_w1c;
        bus_wr(1, STAT, 32'h0FF0_0000);
        rd_chk(1, STAT, 32'h20F0_0000, "R6 flag bits not writable");
        bus_wr(1, STAT, 32'h1000_0000);
        rd_chk(1, STAT, 32'h20F0_0000, "R6 other pending bit write no effect");
        bus_wr(1, STAT, 32'h2000_0000);
        rd_chk(1, STAT, 32'h00F0_0000, "R6 write-one clears");
    endtask

    task automatic t_irq;
        bus_wr(0, CTRL, 32'h0080_0000);
        chk("R7 A irq on te0", 32'(a_irq), 1);
        bus_wr(0, 6'h00, 32'h0000_0A0A);
        chk("R7 A irq drops when te0 clear", 32'(a_irq), 0);
        rd_chk(1, 6'h10, 32'h0000_0A0A, "R7 B rx0 word");
        chk("R7 A irq back on te0", 32'(a_irq), 1);
        bus_wr(0, CTRL, 32'h0);
        chk("R7 A irq masked", 32'(a_irq), 0);
        bus_wr(1, CTRL, 32'h0200_0000);
        chk("R7 B irq idle rf2", 32'(b_irq), 0);
        bus_wr(0, 6'h08, 32'h0000_0033);
        chk("R7 B irq on rf2", 32'(b_irq), 1);
        rd_chk(1, 6'h18, 32'h0000_0033, "R7 B rx2 word");
        chk("R7 B irq off after pop", 32'(b_irq), 0);
        bus_wr(1, CTRL, 32'h4000_0000);
        bus_wr(0, CTRL, 32'h0004_0000);
        chk("R7 B irq not yet on pending1", 32'(b_irq), 0);
        @(negedge clk);
        chk("R7 B irq on pending1", 32'(b_irq), 1);
        bus_wr(1, STAT, 32'h4000_0000);
        chk("R7 B irq off after clear", 32'(b_irq), 0);
        bus_wr(1, CTRL, 32'h0);
    endtask

    task automatic t_misc;
        bus_wr(0, CTRL, 32'hFFF0_FFFF);
        rd_chk(0, CTRL, 32'hFFF0_0000, "R8 control readback");
        chk("R8 A irq with all enables", 32'(a_irq), 1);
        bus_wr(0, CTRL, 32'h0);
        rd_chk(0, 6'h28, 32'h0, "R8 unmapped reads 0");
        rd_chk(0, 6'h02, 32'h0, "R8 misaligned reads 0");
        rd_chk(0, 6'h00, 32'h0, "R8 transmit slot reads 0");
        bus_wr(1, 6'h10, 32'h0000_0099);
        rd_chk(1, STAT, 32'h00F0_0000, "R8 receive write no flag change");
        rd_chk(1, 6'h10, 32'h0000_0A0A, "R8 receive write ignored");
    endtask

    task automatic t_collide;
        bus_wr(0, 6'h08, 32'h0000_0100);
        a_wr = 1'b1; a_addr = 6'h08; a_wdata = 32'h0000_0200;
        b_rd = 1'b1; b_addr = 6'h18;
        #1;
        chk("R10 reader gets old word", b_rdata, 32'h0000_0100);
        @(negedge clk);
        a_wr = 1'b0;
        b_rd = 1'b0;
        rd_chk(0, STAT, 32'h00D0_0000, "R10 A te2 still clear");
        rd_chk(1, STAT, 32'h02F0_0000, "R10 B rf2 still set");
        rd_chk(1, 6'h18, 32'h0000_0200, "R10 new word held");
        rd_chk(0, STAT, 32'h00F0_0000, "R10 drained");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_data_ab();
        t_overwrite();
        t_data_ba();
        t_doorbell();
        t_w1c();
        t_irq();
        t_misc();
        t_collide();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule